// File: doc/BRIEF.md
# Bit-Addressable Special Register File

This block holds the special-function registers of a small 8-bit microcontroller core. It has 21 byte registers at fixed addresses in the upper half of an 8-bit space. Eleven of them, the ones whose address ends in 0 or 8, can also be read and written one bit at a time through a separate bit port. The instruction logic uses the byte port for moves and arithmetic results and the bit port for set, clear and test operations. The two ports work side by side in the same cycle.

The status word does not store its parity flag. That flag is computed from the accumulator, and the status word's reserved bit is held at zero. The two register-bank select bits of the status word are driven out so the data-RAM addressing can use them. Reset loads each register with its own value. The serial buffer is the only register that reset does not touch.

Top module: `sfr_bank`

## Requirements
- R1: Byte addresses 80H, 81H, 82H, 83H, 87H, 88H, 89H, 8AH, 8BH, 8CH, 8DH, 90H, 98H, 99H, A0H, A8H, B0H, B8H, D0H, E0H and F0H each hold one 8-bit register. A byte write lands at the clock edge where `we_i` is high, and `rdata_o` is a combinational read of `addr_i`.
- R2: A byte read from any other address returns 00H. A byte write to any other address changes no register.
- R3: After reset, 81H reads 07H, and 80H, 90H, A0H and B0H read FFH. Every other register reads 00H, except 99H, which has no reset value.
- R4: Bit address N refers to bit (N AND 07H) of the register at byte address (N AND F8H). `bit_dout_o` reads that bit combinationally.
- R5: A bit write updates only the addressed bit in a single clock edge. The other seven bits of that register keep their values.
- R6: A bit address whose register (N AND F8H) is not one of 80H, 88H, 90H, 98H, A0H, A8H, B0H, B8H, D0H, E0H or F0H reads 0 and changes nothing.
- R7: If a byte write and a bit write hit the same register in the same cycle, the register takes the byte write value.
- R8: Bit 0 of the status word (D0H) reads 1 exactly when the accumulator (E0H) holds an odd number of ones. Byte writes and bit writes to status bit 0 have no effect.
- R9: Status word bit 1 always reads 0.
- R10: `bank_sel_o` equals status bits {4,3}: 00 selects bank 0, 01 bank 1, 10 bank 2 and 11 bank 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Byte write enable |
| wdata_i | input | 8 | Byte write data |
| rdata_o | output | 8 | Byte read data |
| bit_addr_i | input | 8 | Bit address |
| bit_we_i | input | 1 | Bit write enable |
| bit_din_i | input | 1 | Bit write data |
| bit_dout_o | output | 1 | Bit read data |
| bank_sel_o | output | 2 | Register bank select |

## Verification
Reads are combinational, so a wrong stored bit shows on `rdata_o` or `bit_dout_o` in the first cycle after the faulty edge. The read must address the affected register for this to happen.

- A decode fault that aliases two registers shows up after a full write sweep with a distinct pattern per address, because the wrong address then reads another register's value.
- A bit write with a bad merge mask shows up as changed neighbouring bits, seen on a byte read of the same register.
- A parity or bank fault shows at the status word, or on `bank_sel_o`, one cycle after the accumulator or status write.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int AW       = 8;
  localparam int DW       = 8;
  localparam int NUM_REGS = 21;
  localparam int BIT_IW   = $clog2(DW);
  localparam int IDX_PSW  = 18;
  localparam int IDX_ACC  = 19;
  localparam int PSW_P    = 0;
  localparam int PSW_RSV  = 1;
  localparam int PSW_RS0  = 3;
  localparam int PSW_RS1  = 4;
  localparam logic [AW-1:0] ADDR_PSW  = 8'hD0;
  localparam logic [AW-1:0] ADDR_ACC  = 8'hE0;
  localparam logic [AW-1:0] ADDR_SBUF = 8'h99;

  function automatic logic [AW-1:0] reg_addr(input int i);
    case (i)
      0:  return 8'h80;  1:  return 8'h81;  2:  return 8'h82;
      3:  return 8'h83;  4:  return 8'h87;  5:  return 8'h88;
      6:  return 8'h89;  7:  return 8'h8A;  8:  return 8'h8B;
      9:  return 8'h8C;  10: return 8'h8D;  11: return 8'h90;
      12: return 8'h98;  13: return 8'h99;  14: return 8'hA0;
      15: return 8'hA8;  16: return 8'hB0;  17: return 8'hB8;
      18: return 8'hD0;  19: return 8'hE0;  default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rst(input logic [AW-1:0] a);
    case (a)
      8'h81:                      return 8'h07;
      8'h80, 8'h90, 8'hA0, 8'hB0: return 8'hFF;
      default:                    return 8'h00;
    endcase
  endfunction

  // Bits held at zero in storage (PSW parity is derived, PSW bit 1 reserved)
  function automatic logic [DW-1:0] reg_zero_mask(input logic [AW-1:0] a);
    return (a == ADDR_PSW) ? DW'((1 << PSW_P) | (1 << PSW_RSV)) : '0;
  endfunction
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
  import sfr_pkg::*;
#(
  parameter int N = NUM_REGS
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign sel_o[g] = (addr_i == reg_addr(g));
  end
endmodule

// File: rtl/sfr_cell.sv
module sfr_cell
  import sfr_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL   = '0,
  parameter logic [DW-1:0] ZERO_MASK = '0,
  parameter bit            HAS_RST   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              bit_we_i,
  input  logic [BIT_IW-1:0] bit_idx_i,
  input  logic              bit_din_i,
  output logic [DW-1:0]     q_o
);
  logic [DW-1:0] q_q, d;

  always_comb begin
    d = q_q;
    if (byte_we_i)     d = wdata_i;   // byte write wins
    else if (bit_we_i) d[bit_idx_i] = bit_din_i;
    d = d & ~ZERO_MASK;
  end

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= RST_VAL;
      else         q_q <= d;
    end
  end else begin : g_nrst
    always_ff @(posedge clk_i) q_q <= d;
  end

  assign q_o = q_q;

  p_byte_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_we_i |=> q_o == ($past(wdata_i) & ~ZERO_MASK));
  p_bit_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && !byte_we_i) |=>
      (((q_o ^ $past(q_o)) & ~(DW'(1) << $past(bit_idx_i))) == '0));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_we_i && !bit_we_i) |=> $stable(q_o));
endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
  import sfr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] bit_addr_i,
  input  logic       bit_we_i,
  input  logic       bit_din_i,
  output logic       bit_dout_o,
  output logic [1:0] bank_sel_o
);
  logic [NUM_REGS-1:0] byte_sel, bit_sel;
  logic [AW-1:0]       bit_reg_addr;
  logic [DW-1:0]       q    [NUM_REGS];
  logic [DW-1:0]       view [NUM_REGS];
  logic [DW-1:0]       bit_byte;
  logic                parity;

  // Only registers at xxxxx000 can match, i.e. the bit-addressable set
  assign bit_reg_addr = {bit_addr_i[AW-1:BIT_IW], {BIT_IW{1'b0}}};

  sfr_decode #(.N(NUM_REGS)) u_byte_dec (.addr_i(addr_i),       .sel_o(byte_sel));
  sfr_decode #(.N(NUM_REGS)) u_bit_dec  (.addr_i(bit_reg_addr), .sel_o(bit_sel));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    sfr_cell #(
      .RST_VAL  (reg_rst(reg_addr(g))),
      .ZERO_MASK(reg_zero_mask(reg_addr(g))),
      .HAS_RST  (reg_addr(g) != ADDR_SBUF)
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .byte_we_i(we_i & byte_sel[g]),
      .wdata_i  (wdata_i),
      .bit_we_i (bit_we_i & bit_sel[g]),
      .bit_idx_i(bit_addr_i[BIT_IW-1:0]),
      .bit_din_i(bit_din_i),
      .q_o      (q[g])
    );
    if (g == IDX_PSW) begin : g_psw
      assign view[g] = q[g] | (DW'(parity) << PSW_P);
    end else begin : g_plain
      assign view[g] = q[g];
    end
  end

  assign parity = ^q[IDX_ACC];

  always_comb begin
    rdata_o  = '0;
    bit_byte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (byte_sel[i]) rdata_o  = rdata_o  | view[i];
      if (bit_sel[i])  bit_byte = bit_byte | view[i];
    end
  end

  assign bit_dout_o = bit_byte[bit_addr_i[BIT_IW-1:0]];
  assign bank_sel_o = {q[IDX_PSW][PSW_RS1], q[IDX_PSW][PSW_RS0]};

  p_one_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(byte_sel) && $onehot0(bit_sel));
  p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_sel == '0) |-> (rdata_o == '0));
  p_bit_unmapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_sel == '0) |-> !bit_dout_o);
  p_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_addr_i == ADDR_PSW && addr_i == ADDR_ACC) |-> (bit_dout_o == ^rdata_o));
  p_rsv_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_PSW) |-> !rdata_o[PSW_RSV]);
  p_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_PSW) |-> (bank_sel_o == rdata_o[PSW_RS1:PSW_RS0]));
endmodule

// File: tb/sfr_bank_tb.sv
`timescale 1ns/1ps
module sfr_bank_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, bit_addr = '0;
  logic       we = 1'b0, bit_we = 1'b0, bit_din = 1'b0;
  logic [7:0] rdata;
  logic       bit_dout;
  logic [1:0] bank_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m [256];

  always #10 clk = ~clk;

  sfr_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .bit_addr_i(bit_addr), .bit_we_i(bit_we),
    .bit_din_i(bit_din), .bit_dout_o(bit_dout), .bank_sel_o(bank_sel));

  function automatic bit impl(input logic [7:0] a);
    case (a)
      8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C,
      8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hD0, 8'hE0,
      8'hF0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit bitable(input logic [7:0] a);
    return impl(a) && (a[2:0] == 3'b000);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (!impl(a)) return 8'h00;
    if (a == 8'hD0) return {m[8'hD0][7:2], 1'b0, ^m[8'hE0]};
    return m[a];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    if (impl(a)) m[a] = (a == 8'hD0) ? (d & 8'hFC) : d;
  endtask

  task automatic bit_wr(input logic [7:0] n, input logic v);
    logic [7:0] r;
    r = n & 8'hF8;
    @(negedge clk); bit_addr = n; bit_din = v; bit_we = 1'b1;
    @(negedge clk); bit_we = 1'b0;
    if (bitable(r)) begin
      m[r][n[2:0]] = v;
      if (r == 8'hD0) m[r] = m[r] & 8'hFC;
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    addr = a; #1;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) m[a] = 8'h00;
    m[8'h81] = 8'h07;
    m[8'h80] = 8'hFF; m[8'h90] = 8'hFF; m[8'hA0] = 8'hFF; m[8'hB0] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset values (SBUF skipped)
    for (int a = 0; a < 256; a++)
      if (a != 8'h99) rd_chk("R3", 8'(a));
    chk("R10 reset", {6'b0, bank_sel}, 8'h00);

    // R1/R2: two full byte sweeps with distinct per-address patterns
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++)
        byte_wr(8'(a), (p == 0) ? 8'((a * 37 + 11) & 255) : ~8'((a * 53 + 5) & 255));
      for (int a = 0; a < 256; a++)
        rd_chk(impl(8'(a)) ? "R1" : "R2", 8'(a));
    end

    // R4/R5/R6: bit sweep over every bit address
    for (int n = 0; n < 256; n++) begin
      logic [7:0] r;
      logic v;
      r = 8'(n) & 8'hF8;
      bit_addr = 8'(n); #1;
      chk(bitable(r) ? "R4" : "R6", {7'b0, bit_dout},
          {7'b0, bitable(r) ? exp_rd(r)[n % 8] : 1'b0});
      v = ~bit_dout ^ n[3];
      bit_wr(8'(n), v);
      bit_addr = 8'(n); #1;
      chk(bitable(r) ? "R5 bit" : "R6 bit", {7'b0, bit_dout},
          {7'b0, bitable(r) ? exp_rd(r)[n % 8] : 1'b0});
      rd_chk(bitable(r) ? "R5 byte" : "R6 byte", r);
      if (!bitable(r) && impl(r)) rd_chk("R6 impl", r);
    end

    // R7: same-cycle byte and bit write to the accumulator
    @(negedge clk);
    addr = 8'hE0; wdata = 8'h5A; we = 1'b1;
    bit_addr = 8'hE7; bit_din = 1'b1; bit_we = 1'b1;
    @(negedge clk); we = 1'b0; bit_we = 1'b0;
    m[8'hE0] = 8'h5A;
    rd_chk("R7", 8'hE0);

    // R8: parity for every accumulator value, via byte and bit reads
    for (int v = 0; v < 256; v++) begin
      byte_wr(8'hE0, 8'(v));
      rd_chk("R8", 8'hD0);
      bit_addr = 8'hD0; #1;
      chk("R8 bit", {7'b0, bit_dout}, {7'b0, ^8'(v)});
    end
    // R8/R9: writes to P and reserved bit have no effect
    byte_wr(8'hE0, 8'h01);
    byte_wr(8'hD0, 8'hFE);
    rd_chk("R8 write P", 8'hD0);
    byte_wr(8'hD0, 8'h03);
    rd_chk("R9", 8'hD0);
    bit_wr(8'hD0, 1'b0);
    bit_wr(8'hD1, 1'b1);
    rd_chk("R9 bit", 8'hD0);

    // R10: bank select for all four encodings
    for (int k = 0; k < 4; k++) begin
      byte_wr(8'hD0, 8'(k << 3) | 8'hE4);
      addr = 8'h00; #1;
      chk("R10", {6'b0, bank_sel}, 8'(k));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule